// File: doc/BRIEF.md
# Odd-Stride Accumulator Test Pattern Generator

This block produces stimulus for groups of logic under test. A wide accumulator register gains a fixed odd increment on every enabled clock of a run. Because the increment is odd, the low field of the sum passes through every possible value once before it repeats. That field is the test pattern, and the order it arrives in is scrambled rather than counting upward. The accumulator is 48 bits wide by default, the width of a multiply-accumulate slice. The default increment is 0x691.

A run begins with a one-cycle start pulse, which zeroes the sum. The run lasts exactly 2^PAT_W enabled steps. After the last step a done flag is raised, and the pattern then stays fixed until the next start. Enable can pause the run at any cycle. Two pattern buses carry the same value. Each drives one of two alternating columns of blocks under test, so that neighbouring blocks see identical stimulus and their responses can be compared.

Top module: `stride_pattern_gen`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) leaves both pattern buses at 0 and done at 0.
- R2: A start pulse at a clock edge zeroes the accumulator, clears done and begins a run, whatever the level of en. Stepping begins at the next enabled edge.
- R3: In a run, each edge with en high and start low adds STEP (default 0x691) to the accumulator. The pattern bus is the low PAT_W bits of the accumulator. After n steps it equals (n*STEP) mod 2^PAT_W, which is n*0x91 mod 256 with the defaults.
- R4: An edge with en low and start low changes neither the patterns nor done. Before the first start, en has no effect.
- R5: pat_b always equals pat_a.
- R6: done rises at the edge of the 2^PAT_W-th enabled step of a run and not earlier. After that edge no further step occurs.
- R7: The 2^PAT_W patterns seen during one run are all distinct.
- R8: While done is high the pattern is 0, and done stays high until the next start.
- R9: A start during a run or after done restarts the run from zero with the count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step enable |
| start | input | 1 | One-cycle pulse that zeroes the accumulator and begins a run |
| pat_a | output | PAT_W | Pattern for the first column of blocks under test |
| pat_b | output | PAT_W | Pattern for the alternate column, equal to pat_a |
| done | output | 1 | High once a run has made all 2^PAT_W steps |

## Verification
Every result is due at the first rising edge after the inputs that cause it: the pattern, the zeroing by start and the rise of done each take one register stage. The bench changes inputs on falling edges and compares the outputs on the next falling edge, half a period after the edge that updates them. Expected values come from the step count, as (n*STEP) mod 2^PAT_W, and not from a running sum. This catches a wrong increment, a hold that is missed and a done that comes one step early or late.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_FIN  = 2'd2
  } phase_t;

  // Accumulator update: running sum plus the fixed stride.
  function automatic logic [63:0] add_stride(input logic [63:0] sum,
                                             input logic [63:0] stride);
    return sum + stride;
  endfunction

  // The terminal step is reached when every bit of the step count is set.
  function automatic logic is_terminal(input logic [63:0] count,
                                       input int unsigned width);
    logic all_set;
    all_set = 1'b1;
    for (int i = 0; i < 64; i++) begin
      if (i < int'(width) && !count[i]) all_set = 1'b0;
    end
    return all_set;
  endfunction

endpackage

// File: rtl/tpg_accum.sv
module tpg_accum #(
  parameter int unsigned ACC_W  = 48,
  parameter logic [63:0] STRIDE = 64'h691
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [ACC_W-1:0] sum
);
  import tpg_pkg::*;

  localparam logic [ACC_W-1:0] ZERO = '0;

  logic [ACC_W-1:0] sum_q;
  logic [ACC_W-1:0] sum_next;

  always_comb begin
    sum_next = ACC_W'(add_stride(64'(sum_q), STRIDE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= ZERO;
    end else if (clear) begin
      sum_q <= ZERO;
    end else if (advance) begin
      sum_q <= sum_next;
    end
  end

  assign sum = sum_q;

endmodule

// File: rtl/tpg_seq.sv
module tpg_seq #(
  parameter int unsigned CNT_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic en,
  output logic step_fire,
  output logic last_step,
  output logic done
);
  import tpg_pkg::*;

  phase_t             phase_q;
  logic [CNT_W-1:0]   cnt_q;

  always_comb begin
    step_fire = (phase_q == PH_RUN) && en && !start;
    last_step = step_fire && is_terminal(64'(cnt_q), CNT_W);
    done      = (phase_q == PH_FIN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
    end else if (step_fire) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_step) phase_q <= PH_FIN;
    end
  end

endmodule

// File: rtl/stride_pattern_gen.sv
module stride_pattern_gen #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned PAT_W = 8,
  parameter logic [63:0] STEP  = 64'h691
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  output logic [PAT_W-1:0] pat_a,
  output logic [PAT_W-1:0] pat_b,
  output logic             done
);

  localparam int unsigned LANES = 2;

  // Internal events, named so that the checker can observe them.
  logic             step_fire;
  logic             last_step;
  logic [ACC_W-1:0] acc_sum;
  logic [PAT_W-1:0] lane_pat [LANES];

  tpg_seq #(.CNT_W(PAT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .en        (en),
    .step_fire (step_fire),
    .last_step (last_step),
    .done      (done)
  );

  tpg_accum #(.ACC_W(ACC_W), .STRIDE(STEP)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clear   (start),
    .advance (step_fire),
    .sum     (acc_sum)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_pat[g] = acc_sum[PAT_W-1:0];
  end

  assign pat_a = lane_pat[0];
  assign pat_b = lane_pat[1];

endmodule

// File: rtl/stride_pattern_gen_chk.sv
module stride_pattern_gen_chk #(
  parameter int unsigned PAT_W = 8,
  parameter logic [63:0] STEP  = 64'h691
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             start,
  input logic [PAT_W-1:0] pat_a,
  input logic [PAT_W-1:0] pat_b,
  input logic             done,
  input logic             step_fire,
  input logic             last_step
);
  localparam logic [PAT_W-1:0] STEP_LO = STEP[PAT_W-1:0];

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (pat_a == '0) && !done); // R1
  AST_START_ZERO: assert property (@(posedge clk) disable iff (rst) start |=> (pat_a == '0) && !done); // R2
  AST_STEP_ADD: assert property (@(posedge clk) disable iff (rst) step_fire |=> pat_a == PAT_W'($past(pat_a) + STEP_LO)); // R3
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst) (!en && !start) |=> $stable(pat_a) && $stable(done)); // R4
  AST_LANES_EQUAL: assert property (@(posedge clk) disable iff (rst) pat_a == pat_b); // R5
  AST_LAST_DONE: assert property (@(posedge clk) disable iff (rst) last_step |=> done); // R6
  AST_NO_STEP_DONE: assert property (@(posedge clk) disable iff (rst) done |-> !step_fire); // R6
  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (rst) done |-> (pat_a == '0)); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> done); // R8

endmodule

bind stride_pattern_gen stride_pattern_gen_chk #(.PAT_W(PAT_W), .STEP(STEP)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .start     (start),
  .pat_a     (pat_a),
  .pat_b     (pat_b),
  .done      (done),
  .step_fire (step_fire),
  .last_step (last_step)
);

// File: tb/stride_pattern_gen_test.sv
`timescale 1ns/1ps
module stride_pattern_gen_test;
  localparam int K   = 8;
  localparam int N   = 1 << K;
  localparam longint STRIDE = 64'h691;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic start = 1'b0;
  logic [K-1:0] pat_a, pat_b;
  logic done;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  // Model: step count and phase (0 idle, 1 running, 2 done)
  int m_cnt = 0;
  int m_phase = 0;

  always #4 clk = ~clk;

  stride_pattern_gen uut (
    .clk(clk), .rst(rst), .en(en), .start(start),
    .pat_a(pat_a), .pat_b(pat_b), .done(done)
  );

  function automatic int exp_pat(input int steps);
    longint prod;
    prod = longint'(steps) * STRIDE;
    return int'(prod % longint'(N));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  // Drive one cycle, advance the model, compare at the following falling edge.
  task automatic tick(input bit r, input bit e, input bit s, input string tag);
    rst = r; en = e; start = s;
    @(posedge clk);
    if (r) begin
      m_cnt = 0; m_phase = 0;
    end else if (s) begin
      m_cnt = 0; m_phase = 1;
    end else if (m_phase == 1 && e) begin
      m_cnt++;
      if (m_cnt == N) m_phase = 2;
    end
    @(negedge clk);
    check({tag, " pat_a"}, int'(pat_a), (m_phase == 0) ? 0 : exp_pat(m_cnt));
    check("R5 pat_b", int'(pat_b), int'(pat_a));
    check({tag, " done"}, int'(done), (m_phase == 2) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    bit seen [N];
    void'($urandom(32'd20240611));

    // R1: reset state
    tick(1, 0, 0, "R1");
    tick(1, 1, 0, "R1");
    // R4: en has no effect before the first start
    for (int i = 0; i < 5; i++) tick(0, 1, 0, "R4 idle");

    // R2: start zeroes and begins a run
    tick(0, 0, 1, "R2");
    for (int i = 0; i < N; i++) seen[i] = 1'b0;
    seen[int'(pat_a)] = 1'b1;
    // R3/R6/R7: full run with en high
    for (int i = 1; i <= N; i++) begin
      tick(0, 1, 0, (i == N) ? "R6 final" : "R3");
      if (i < N) begin
        n_chk++;
        if (seen[int'(pat_a)]) begin
          n_err++;
          $display("FAIL R7: actual repeat %0d expected unseen value", pat_a);
        end
        seen[int'(pat_a)] = 1'b1;
      end
    end
    check("R8 pattern zero at done", int'(pat_a), 0);
    // R6/R8: no stepping after done, done held
    for (int i = 0; i < 4; i++) tick(0, 1, 0, "R8 hold");

    // R9: restart after done, pause, restart mid-run
    tick(0, 1, 1, "R9 restart");
    for (int i = 0; i < 10; i++) tick(0, 1, 0, "R3");
    for (int i = 0; i < 3; i++) tick(0, 0, 0, "R4 pause");
    tick(0, 0, 1, "R9 midrun start en low");
    for (int i = 0; i < 7; i++) tick(0, 1, 0, "R3");
    check("R9 seven steps", int'(pat_a), exp_pat(7));

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      bit e, s, r;
      e = ($urandom % 4) != 0;
      s = ($urandom % 400) == 0;
      r = ($urandom % 1500) == 0;
      tick(r, e, s, "R3 random");
      if (i % 1000 == 999) tick(0, 1, 1, "R2 random");
    end

    // Long run to completion with pauses
    tick(0, 0, 1, "R2");
    while (m_phase != 2) tick(0, ($urandom % 3) != 0, 0, "R6 paused run");
    tick(0, 1, 0, "R8 hold");

    summary();
  end

endmodule